// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block keeps a programmable mode word for an SDRAM-style memory controller and, once a burst command arrives, produces the column address for every beat of the burst. The mode word selects the burst length (1, 2, 4 or 8 beats, or a full page), the address order (sequential or interleaved), the CAS latency and whether writes burst or move a single beat. A mode word that uses a reserved code is refused, and a flag reports the refusal.

A controller drives a burst-start strobe with a read/write flag and a starting column. The sequencer then shows one column per enabled clock, with a valid flag and a last-beat flag. A new command may arrive on any clock, including during a running burst. It drops the rest of the old burst and starts again with the full length. A full-page burst runs until a stop input or a new command ends it. When the clock enable is low, the sequencer holds its whole state.

Top module: `sdr_burst_seq`

## Requirements
- R1: A mode load is accepted only when mode_word_i[13:10], mode_word_i[8] and mode_word_i[7] are all 0, the CAS code [6:4] is 2, 3 or 4, and the length code [2:0] is 0 to 3, or 7 with bit 3 at 0. A refused load sets mode_err_o and keeps the previous mode. An accepted load clears mode_err_o. Both take effect on the clock after the load.
- R2: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats.
- R3: cas_lat_o shows the CAS code of the held mode (2, 3 or 4). It is 2 after reset, and the reset mode is sequential with a 1-beat length and burst writes.
- R4: With bit 3 at 0 (sequential), beat i shows the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits stay fixed.
- R5: With bit 3 at 1 (interleaved), beat i shows the start column XOR i.
- R6: Length code 7 in sequential order gives a full-page burst. It starts at the start column, adds 1 each beat, wraps from 255 to 0 and never raises last_o. It ends on the clock after burst_stop_i.
- R7: With bit 9 at 1, a write command gives one beat with last_o high, while read commands use the programmed length. With bit 9 at 0, writes use the programmed length.
- R8: A command during a burst restarts at its own start column with the full length on the next clock, whether it is a read or a write. A command takes priority over burst_stop_i in the same cycle.
- R9: A mode load is ignored, for the mode word and for mode_err_o, while valid_o is high.
- R10: While cke_i is low, the column, the flags and the mode do not change, and commands, stops and mode loads are ignored.
- R11: valid_o goes high on the clock after an enabled command. last_o is high only on the final beat of a finite burst, and valid_o drops on the clock after that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable; when low, all state holds |
| mode_load_i | input | 1 | Mode-load strobe |
| mode_word_i | input | 14 | Mode word to load |
| cmd_start_i | input | 1 | Burst-start strobe |
| cmd_write_i | input | 1 | 1 for a write command, 0 for a read |
| cmd_col_i | input | 8 | Starting column |
| burst_stop_i | input | 1 | Ends the running burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is shown |
| last_o | output | 1 | Final beat of a finite burst |
| cas_lat_o | output | 3 | CAS latency of the held mode |
| mode_err_o | output | 1 | The last considered load was refused |

## Verification
The bench builds the block with its default 8-bit column, so the page holds 256 columns. This lets the full-page test cross the 255-to-0 wrap in a few beats by starting near the top of the page. The start columns are chosen so that sequential bursts wrap inside their block while the upper column bits stay fixed, and so that interleaved bursts flip the low bits in XOR order instead of counting.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int MODE_W = 14;

  typedef struct packed {
    logic       wr_single;
    logic [2:0] cl;
    logic       ilv;
    logic [2:0] bl;
  } mode_t;

  localparam mode_t MODE_RST = '{wr_single: 1'b0, cl: 3'd2, ilv: 1'b0, bl: 3'd0};
  localparam logic [2:0] BL_PAGE = 3'd7;

  function automatic logic mode_legal(input logic [MODE_W-1:0] w);
    logic zero_ok, bl_ok, cl_ok;
    zero_ok = (w[13:10] == 4'b0) && (w[8:7] == 2'b0);
    bl_ok   = (w[2:0] <= 3'd3) || ((w[2:0] == BL_PAGE) && !w[3]);
    cl_ok   = (w[6:4] >= 3'd2) && (w[6:4] <= 3'd4);
    return zero_ok && bl_ok && cl_ok;
  endfunction

  function automatic mode_t mode_unpack(input logic [MODE_W-1:0] w);
    return '{wr_single: w[9], cl: w[6:4], ilv: w[3], bl: w[2:0]};
  endfunction
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  input  logic              busy_i,
  output mode_t             mode_o,
  output logic [2:0]        cas_lat_o,
  output logic              err_o
);
  mode_t mode_q;
  logic  err_q;
  logic  take;

  assign take = cke_i && load_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else if (take) begin
      if (mode_legal(word_i)) begin
        mode_q <= mode_unpack(word_i);
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign cas_lat_o = mode_q.cl;
  assign err_o     = err_q;

  assert_load_busy_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy_i) |=> ($stable(mode_q) && $stable(err_q)));
  assert_reject_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !mode_legal(word_i)) |=> (err_o && $stable(mode_q)));
  assert_cas_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_o >= 3'd2 && cas_lat_o <= 3'd4));
  assert_cke_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(mode_q) && $stable(err_q)));
endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stop_i,
  input  mode_t            mode_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q, ilv_q, full_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d, at_end;

  always_comb begin
    full_d = 1'b0;
    if (write_i && mode_i.wr_single) begin
      mask_d = '0;
    end else if (mode_i.bl == BL_PAGE) begin
      mask_d = '1;
      full_d = 1'b1;
    end else begin
      mask_d = (ONE << mode_i.bl) - ONE;
    end
  end

  assign at_end = !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (cke_i) begin
      if (start_i) begin
        active_q <= 1'b1;
        base_q   <= col_i;
        cnt_q    <= '0;
        mask_q   <= mask_d;
        full_q   <= full_d;
        ilv_q    <= mode_i.ilv;
      end else if (active_q) begin
        if (stop_i || at_end) active_q <= 1'b0;
        else                  cnt_q    <= cnt_q + ONE;
      end
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign full_o   = full_q;
  assign last_o   = active_q && at_end;

  assert_last_needs_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> active_o);
  assert_page_no_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && full_o) |-> !last_o);
  assert_burst_continues_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o && !stop_i) |=> active_o);
  assert_start_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && start_i) |=> (active_o && cnt_o == '0 && base_o == $past(col_i)));
  assert_last_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && last_o && !start_i) |=> !active_o);
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + cnt_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (ilv_i)  col_o[b] = base_i[b] ^ cnt_i[b];
      else             col_o[b] = sum[b];
    end
  end
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              cmd_start_i,
  input  logic              cmd_write_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic              burst_stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [2:0]        cas_lat_o,
  output logic              mode_err_o
);
  mode_t            mode;
  logic             active, ilv, full;
  logic [COL_W-1:0] base, cnt, mask;

  sdr_mode_reg u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_i     (cke_i),
    .load_i    (mode_load_i),
    .word_i    (mode_word_i),
    .busy_i    (active),
    .mode_o    (mode),
    .cas_lat_o (cas_lat_o),
    .err_o     (mode_err_o)
  );

  sdr_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_i    (cke_i),
    .start_i  (cmd_start_i),
    .write_i  (cmd_write_i),
    .col_i    (cmd_col_i),
    .stop_i   (burst_stop_i),
    .mode_i   (mode),
    .active_o (active),
    .base_o   (base),
    .cnt_o    (cnt),
    .mask_o   (mask),
    .ilv_o    (ilv),
    .full_o   (full),
    .last_o   (last_o)
  );

  sdr_col_gen #(.COL_W(COL_W)) u_col (
    .base_i (base),
    .cnt_i  (cnt),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col_o)
  );

  assign valid_o = active;

  assert_upper_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !full) |-> ((col_o & ~mask) == (base & ~mask)));
  assert_page_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && valid_o && full && !cmd_start_i && !burst_stop_i) |=> (col_o == $past(col_o) + COL_W'(1)));
  assert_cke_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(col_o) && $stable(valid_o) && $stable(last_o)));
endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        mload = 1'b0;
  logic [13:0] mword = '0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  scol = '0;
  logic        stop = 1'b0;
  logic [7:0]  col;
  logic        valid, last, err;
  logic [2:0]  cas;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sdr_burst_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .mode_load_i(mload), .mode_word_i(mword),
    .cmd_start_i(start), .cmd_write_i(wr), .cmd_col_i(scol), .burst_stop_i(stop),
    .col_o(col), .valid_o(valid), .last_o(last), .cas_lat_o(cas), .mode_err_o(err)
  );

  function automatic logic [13:0] mw(bit wb, logic [2:0] cl, bit bt, logic [2:0] bl);
    return {4'b0, wb, 2'b0, cl, bt, bl};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load(logic [13:0] w);
    mload = 1'b1; mword = w;
    tick();
    mload = 1'b0;
  endtask

  task automatic cmd(logic [7:0] c, bit w);
    start = 1'b1; scol = c; wr = w;
    tick();
    start = 1'b0;
  endtask

  task automatic beat(logic [7:0] c, bit l, string req);
    chk(valid == 1'b1, req, valid, 1);
    chk(col == c, req, col, c);
    chk(last == l, req, last, l);
    tick();
  endtask

  task automatic idle(string req);
    chk(valid == 1'b0, req, valid, 0);
    chk(last == 1'b0, req, last, 0);
  endtask

  function automatic logic [7:0] seq_col(logic [7:0] s, int i, int len);
    logic [7:0] m;
    m = 8'(len - 1);
    return (s & ~m) | ((s + 8'(i)) & m);
  endfunction

  task automatic t_reset();
    idle("R11 reset");
    chk(cas == 3'd2, "R3 reset", cas, 2);
    chk(err == 1'b0, "R1 reset", err, 0);
    cmd(8'h45, 1'b0);
    beat(8'h45, 1'b1, "R3 reset mode BL1");
    idle("R11 after BL1");
  endtask

  task automatic t_lengths();
    for (int code = 0; code < 4; code++) begin
      int len = 1 << code;
      load(mw(0, 3'd2, 0, 3'(code)));
      cmd(8'h3D, 1'b0);
      for (int i = 0; i < len; i++) beat(seq_col(8'h3D, i, len), i == len - 1, "R2/R4 seq");
      idle("R11 end");
    end
  endtask

  task automatic t_interleave();
    load(mw(0, 3'd2, 1, 3'd3));
    cmd(8'h3D, 1'b0);
    for (int i = 0; i < 8; i++) beat(8'h3D ^ 8'(i), i == 7, "R5 ilv8");
    idle("R5 end");
    load(mw(0, 3'd2, 1, 3'd2));
    cmd(8'hA6, 1'b0);
    for (int i = 0; i < 4; i++) beat(8'hA6 ^ 8'(i), i == 3, "R5 ilv4");
    idle("R5 end4");
  endtask

  task automatic t_cas();
    load(mw(0, 3'd3, 0, 3'd0));
    chk(cas == 3'd3, "R3 cl3", cas, 3);
    load(mw(0, 3'd4, 0, 3'd0));
    chk(cas == 3'd4, "R3 cl4", cas, 4);
    load(mw(0, 3'd2, 0, 3'd0));
    chk(cas == 3'd2, "R3 cl2", cas, 2);
  endtask

  task automatic t_illegal();
    load(mw(0, 3'd3, 0, 3'd1));
    chk(err == 1'b0, "R1 legal", err, 0);
    load(mw(0, 3'd3, 0, 3'd4));
    chk(err == 1'b1, "R1 bl4", err, 1);
    load(mw(0, 3'd2, 1, 3'd7));
    chk(err == 1'b1, "R1 ilv page", err, 1);
    load(mw(0, 3'd5, 0, 3'd0));
    chk(err == 1'b1, "R1 cl5", err, 1);
    load(mw(0, 3'd1, 0, 3'd0));
    chk(err == 1'b1, "R1 cl1", err, 1);
    load(mw(0, 3'd2, 0, 3'd0) | 14'h1000);
    chk(err == 1'b1, "R1 bank bit", err, 1);
    load(mw(0, 3'd2, 0, 3'd0) | 14'h0080);
    chk(err == 1'b1, "R1 bit7", err, 1);
    chk(cas == 3'd3, "R1 kept cl", cas, 3);
    cmd(8'h50, 1'b0);
    beat(8'h50, 1'b0, "R1 kept bl2");
    beat(8'h51, 1'b1, "R1 kept bl2");
    idle("R1 end");
    load(mw(0, 3'd2, 0, 3'd0));
    chk(err == 1'b0, "R1 clear", err, 0);
  endtask

  task automatic t_page();
    load(mw(0, 3'd2, 0, 3'd7));
    chk(err == 1'b0, "R1 page legal", err, 0);
    cmd(8'hFD, 1'b0);
    for (int i = 0; i < 6; i++) beat(8'hFD + 8'(i), 1'b0, "R6 page");
    stop = 1'b1;
    beat(8'h03, 1'b0, "R6 stop beat");
    stop = 1'b0;
    idle("R6 stopped");
  endtask

  task automatic t_single_write();
    load(mw(1, 3'd2, 0, 3'd2));
    cmd(8'h24, 1'b1);
    beat(8'h24, 1'b1, "R7 single write");
    idle("R7 wr end");
    cmd(8'h26, 1'b0);
    for (int i = 0; i < 4; i++) beat(seq_col(8'h26, i, 4), i == 3, "R7 read burst");
    idle("R7 rd end");
    load(mw(0, 3'd2, 0, 3'd2));
    cmd(8'h26, 1'b1);
    for (int i = 0; i < 4; i++) beat(seq_col(8'h26, i, 4), i == 3, "R7 burst write");
    idle("R7 bw end");
  endtask

  task automatic t_interrupt();
    load(mw(0, 3'd2, 0, 3'd3));
    cmd(8'h10, 1'b0);
    for (int i = 0; i < 3; i++) beat(8'h10 + 8'(i), 1'b0, "R8 first");
    stop = 1'b1;
    cmd(8'h2E, 1'b1);
    stop = 1'b0;
    for (int i = 0; i < 8; i++) beat(seq_col(8'h2E, i, 8), i == 7, "R8 restart");
    idle("R8 end");
    cmd(8'h40, 1'b0);
    beat(8'h40, 1'b0, "R8 again");
    cmd(8'h41, 1'b0);
    beat(8'h41, 1'b0, "R8 every clock");
    for (int i = 1; i < 8; i++) beat(seq_col(8'h41, i, 8), i == 7, "R8 tail");
    idle("R8 end2");
  endtask

  task automatic t_load_busy();
    load(mw(0, 3'd2, 0, 3'd2));
    cmd(8'h60, 1'b0);
    mload = 1'b1; mword = mw(0, 3'd4, 0, 3'd0);
    beat(8'h60, 1'b0, "R9 legal during burst");
    mword = mw(0, 3'd6, 0, 3'd0);
    beat(8'h61, 1'b0, "R9 illegal during burst");
    mload = 1'b0;
    chk(cas == 3'd2, "R9 cas kept", cas, 2);
    chk(err == 1'b0, "R9 err kept", err, 0);
    beat(8'h62, 1'b0, "R9 len kept");
    beat(8'h63, 1'b1, "R9 len kept");
    idle("R9 end");
  endtask

  task automatic t_cke();
    cmd(8'h84, 1'b0);
    beat(8'h84, 1'b0, "R10 pre");
    cke = 1'b0;
    start = 1'b1; scol = 8'h77; stop = 1'b1;
    mload = 1'b1; mword = mw(0, 3'd3, 0, 3'd0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(col == 8'h85 && valid, "R10 frozen", col, 8'h85);
    end
    chk(cas == 3'd2, "R10 mode frozen", cas, 2);
    start = 1'b0; stop = 1'b0; mload = 1'b0;
    cke = 1'b1;
    beat(8'h85, 1'b0, "R10 resume");
    beat(8'h86, 1'b0, "R10 resume");
    beat(8'h87, 1'b1, "R10 resume");
    idle("R10 end");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    tick();
    t_reset();
    t_lengths();
    t_interleave();
    t_cas();
    t_illegal();
    t_page();
    t_single_write();
    t_interrupt();
    t_load_busy();
    t_cke();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule